// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block runs one DMA channel cycle. It loads a 32-bit packed channel control word together with a source end pointer and a destination end pointer. From the control word it decodes the element size, the address step on each side, the transfer count and the arbitration group size. It then moves the data one element at a time: each transfer is a read from the source followed by a write of that same data to the destination, on a simple valid/ready memory port.

Addresses are formed backwards from the end pointers, so the last transfer of a cycle always hits the end pointer itself. After every group of 2^R transfers the engine yields. In a basic cycle it waits for the channel request line before the next group. In an auto cycle it inserts one idle cycle and then continues. When the cycle stops it raises a one-clock completion pulse and presents the control word to be written back, with the count and cycle-type fields cleared.

Ping-pong and the scatter-gather types are recognised and reported as unsupported. Inconsistent size settings are reported as an error. In neither case is any bus traffic issued.

Top module: `dma_xfer_engine`

## Requirements
- R1: While reset is high and after it is released, busy, done, err, unsup and mem_valid are low, and ctrl_out is zero.
- R2: Size fields are bits 25:24 (source) and 29:28 (destination), encoded 0 byte, 1 halfword, 2 word, 3 reserved. If the cycle type is not 0 and either size is 3 or the two sizes differ, the engine issues no bus request and raises err together with done for one cycle.
- R3: A running cycle performs N = ctrl[13:4] + 1 transfers (1 to 1024). Each transfer is one read and then one write, and the write data equals the data returned by the preceding read.
- R4: Step fields are bits 27:26 (source) and 31:30 (destination), encoded 0 = 1, 1 = 2, 2 = 4, 3 = hold. Transfer k (k = 0 to N-1) uses the address end - ((N-1-k) * step); with hold, every transfer uses the end pointer.
- R5: The group size is 2^min(R,10), where R = ctrl[17:14]. In a basic cycle (type 1) no bus request is made before chan_req is seen high, both before the first group and before each later group.
- R6: An auto cycle (type 2) starts without chan_req. Between groups it has exactly one cycle with busy high and mem_valid low.
- R7: Cycle type 0 (bits 2:0) finishes with done and no bus traffic, and without err or unsup.
- R8: Cycle types 3 to 7 with valid, equal sizes finish with unsup and done and no bus traffic. A size error takes priority over unsupported.
- R9: Every stop gives exactly one done cycle, and busy is low in the following cycle. ctrl_out then equals the loaded control word with bits 13:4 and 2:0 cleared; the next-burst bit 3 and the protection bits 23:18 are kept.
- R10: A bus request keeps its direction, address and size until mem_ready is seen. mem_size carries the source size encoding.
- R11: start is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load the control word and end pointers (taken only while idle) |
| ctrl_in | input | 32 | Packed channel control word |
| src_end | input | AW | Source end pointer |
| dst_end | input | AW | Destination end pointer |
| chan_req | input | 1 | Channel request that releases each group of a basic cycle |
| mem_valid | output | 1 | Bus request active |
| mem_write | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Bus address |
| mem_size | output | 2 | Element size encoding |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Request accepted in this cycle |
| mem_rdata | input | DW | Read data, valid when a read is accepted |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-cycle stop pulse |
| err | output | 1 | Size error, asserted with done |
| unsup | output | 1 | Unsupported cycle type, asserted with done |
| ctrl_out | output | 32 | Control word to write back, valid from done onwards |

## Verification
The bench targets the group boundary. An engine that got it wrong would either add a second idle cycle in auto mode or run past a group in basic mode without a fresh request. It also checks the last transfer, which must land exactly on the end pointer; an off-by-one address generator would stop one step short of the end pointer or run past it. Hold addressing and the 1024-transfer maximum are both exercised; a count register that is too narrow would wrap to zero transfers. The bench also covers size errors that coincide with unsupported types, and a start pulse issued while a basic cycle is stalled, which a careless design would accept and abort.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    localparam int CW     = 32;      // control word width
    localparam int CNT_W  = 10;      // transfer count field width
    localparam int RP_MAX = CNT_W;   // largest useful group exponent

    typedef enum logic [1:0] {
        STEP_1    = 2'd0,
        STEP_2    = 2'd1,
        STEP_4    = 2'd2,
        STEP_HOLD = 2'd3
    } step_e;

    typedef enum logic [1:0] {
        SZ_8   = 2'd0,
        SZ_16  = 2'd1,
        SZ_32  = 2'd2,
        SZ_BAD = 2'd3
    } width_e;

    typedef enum logic [2:0] {
        CY_STOP  = 3'd0,
        CY_BASIC = 3'd1,
        CY_AUTO  = 3'd2,
        CY_PP    = 3'd3,
        CY_MSG_P = 3'd4,
        CY_MSG_A = 3'd5,
        CY_PSG_P = 3'd6,
        CY_PSG_A = 3'd7
    } cyc_e;

    // Field order follows the bit positions a software writer packs.
    typedef struct packed {
        step_e            dst_step;
        width_e           dst_w;
        step_e            src_step;
        width_e           src_w;
        logic [2:0]       dst_prot;
        logic [2:0]       src_prot;
        logic [3:0]       rpow;
        logic [CNT_W-1:0] nm1;
        logic             burst_nxt;
        cyc_e             cyc;
    } ctrl_t;

    typedef enum logic [1:0] {
        PL_RUN   = 2'd0,
        PL_EMPTY = 2'd1,
        PL_BADSZ = 2'd2,
        PL_UNSUP = 2'd3
    } plan_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_RD   = 3'd2,
        ST_WR   = 3'd3,
        ST_GAP  = 3'd4,
        ST_FIN  = 3'd5
    } st_e;

    // Mask of the in-group transfer counter: 2^min(rp,RP_MAX) - 1.
    // At the limit the shift wraps to zero and the subtraction gives all ones.
    function automatic logic [CNT_W-1:0] group_mask(input logic [3:0] rp);
        logic [3:0] rc;
        rc = (rp > 4'(RP_MAX)) ? 4'(RP_MAX) : rp;
        return (CNT_W'(1) << rc) - CNT_W'(1);
    endfunction

    // Word handed back at the stop: count and cycle type cleared.
    function automatic ctrl_t finish_word(input ctrl_t c);
        ctrl_t r;
        r     = c;
        r.nm1 = '0;
        r.cyc = CY_STOP;
        return r;
    endfunction

endpackage

// File: rtl/dma_ctrl_decode.sv
module dma_ctrl_decode
    import dma_xfer_pkg::*;
(
    input  logic [CW-1:0] word,
    output ctrl_t         fld,
    output plan_e         plan
);
    logic size_bad;

    always_comb begin
        fld      = ctrl_t'(word);
        size_bad = (fld.src_w == SZ_BAD) || (fld.dst_w == SZ_BAD) ||
                   (fld.src_w != fld.dst_w);
        if (fld.cyc == CY_STOP)
            plan = PL_EMPTY;
        else if (size_bad)
            plan = PL_BADSZ;
        else if ((fld.cyc == CY_BASIC) || (fld.cyc == CY_AUTO))
            plan = PL_RUN;
        else
            plan = PL_UNSUP;
    end
endmodule

// File: rtl/dma_addr_calc.sv
module dma_addr_calc
    import dma_xfer_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]    end_ptr,
    input  logic [CNT_W-1:0] rem,
    input  step_e            step,
    output logic [AW-1:0]    addr
);
    logic [AW-1:0] back;

    // Distance from the end pointer is the number of transfers still to come.
    always_comb begin
        back = AW'(rem) << 2'(step);
        addr = (step == STEP_HOLD) ? end_ptr : (end_ptr - back);
    end
endmodule

// File: rtl/dma_grp_track.sv
module dma_grp_track
    import dma_xfer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic [CNT_W-1:0] mask,
    output logic             at_edge
);
    logic [CNT_W-1:0] cnt;

    assign at_edge = (cnt == mask);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (adv)
            cnt <= at_edge ? '0 : (cnt + 1'b1);
    end
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_xfer_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] ctrl_in,
    input  logic [AW-1:0] src_end,
    input  logic [AW-1:0] dst_end,
    input  logic          chan_req,
    output logic          mem_valid,
    output logic          mem_write,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          unsup,
    output logic [CW-1:0] ctrl_out
);
    localparam int SIDES = 2;
    localparam int SRC   = 0;
    localparam int DST   = 1;

    st_e              st;
    ctrl_t            dec_fld;
    plan_e            dec_plan;
    ctrl_t            cfg;
    logic [AW-1:0]    ends      [SIDES];
    logic [AW-1:0]    side_addr [SIDES];
    step_e            side_step [SIDES];
    logic [CNT_W-1:0] rem;
    logic [DW-1:0]    data_q;
    logic             err_q;
    logic             uns_q;
    logic [CW-1:0]    wb_q;
    logic [CNT_W-1:0] grp_mask_w;
    logic             grp_edge;
    logic             wr_fire;

    dma_ctrl_decode u_dec (
        .word (ctrl_in),
        .fld  (dec_fld),
        .plan (dec_plan)
    );

    assign side_step[SRC] = cfg.src_step;
    assign side_step[DST] = cfg.dst_step;

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        dma_addr_calc #(.AW(AW)) u_addr (
            .end_ptr (ends[g]),
            .rem     (rem),
            .step    (side_step[g]),
            .addr    (side_addr[g])
        );
    end

    assign grp_mask_w = group_mask(cfg.rpow);
    assign wr_fire    = (st == ST_WR) && mem_ready;

    dma_grp_track u_grp (
        .clk     (clk),
        .rst     (rst),
        .clr     (st == ST_IDLE),
        .adv     (wr_fire),
        .mask    (grp_mask_w),
        .at_edge (grp_edge)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cfg    <= ctrl_t'('0);
            rem    <= '0;
            data_q <= '0;
            err_q  <= 1'b0;
            uns_q  <= 1'b0;
            wb_q   <= '0;
            for (int i = 0; i < SIDES; i++) ends[i] <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        cfg       <= dec_fld;
                        ends[SRC] <= src_end;
                        ends[DST] <= dst_end;
                        rem       <= dec_fld.nm1;
                        err_q     <= (dec_plan == PL_BADSZ);
                        uns_q     <= (dec_plan == PL_UNSUP);
                        if (dec_plan == PL_RUN) begin
                            st <= (dec_fld.cyc == CY_BASIC) ? ST_WAIT : ST_RD;
                        end else begin
                            wb_q <= finish_word(dec_fld);
                            st   <= ST_FIN;
                        end
                    end
                end
                ST_WAIT: begin
                    if (chan_req) st <= ST_RD;
                end
                ST_RD: begin
                    if (mem_ready) begin
                        data_q <= mem_rdata;
                        st     <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (mem_ready) begin
                        if (rem == '0) begin
                            wb_q <= finish_word(cfg);
                            st   <= ST_FIN;
                        end else begin
                            rem <= rem - 1'b1;
                            if (grp_edge)
                                st <= (cfg.cyc == CY_BASIC) ? ST_WAIT : ST_GAP;
                            else
                                st <= ST_RD;
                        end
                    end
                end
                ST_GAP:  st <= ST_RD;
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign mem_valid = (st == ST_RD) || (st == ST_WR);
    assign mem_write = (st == ST_WR);
    assign mem_addr  = (st == ST_WR) ? side_addr[DST] : side_addr[SRC];
    assign mem_size  = cfg.src_w;
    assign mem_wdata = data_q;
    assign busy      = (st != ST_IDLE);
    assign done      = (st == ST_FIN);
    assign err       = done && err_q;
    assign unsup     = done && uns_q;
    assign ctrl_out  = wb_q;

endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_valid,
    input logic          mem_write,
    input logic [AW-1:0] mem_addr,
    input logic [1:0]    mem_size,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ready,
    input logic [DW-1:0] mem_rdata,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic          unsup,
    input logic [31:0]   ctrl_out
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!busy && !mem_valid && !done && !err && !unsup && ctrl_out == 32'd0));

    assert_flag_no_bus_R2: assert property (@(posedge clk) disable iff (rst)
        (err || unsup) |-> !$past(mem_valid));

    assert_read_then_write_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_write && mem_ready) |=> (mem_valid && mem_write));

    assert_write_data_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_write && mem_ready) |=> (mem_wdata == $past(mem_rdata)));

    assert_flag_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(err && unsup));

    assert_flag_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        (err || unsup) |-> done);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    assert_wb_cleared_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (ctrl_out[13:4] == 10'd0 && ctrl_out[2:0] == 3'd0));

    assert_bus_only_busy_R3: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> busy);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_write) && $stable(mem_addr) && $stable(mem_size)));
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/dma_xfer_engine_bench.sv
module dma_xfer_engine_bench;
    localparam int AW       = 32;
    localparam int DW       = 32;
    localparam int LOGN     = 4096;
    localparam int WD_LIMIT = 150000;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [31:0]   ctrl_in;
    logic [AW-1:0] src_end;
    logic [AW-1:0] dst_end;
    logic          chan_req;
    logic          mem_valid;
    logic          mem_write;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_size;
    logic [DW-1:0] mem_wdata;
    logic          mem_ready;
    logic [DW-1:0] mem_rdata;
    logic          busy;
    logic          done;
    logic          err;
    logic          unsup;
    logic [31:0]   ctrl_out;

    dma_xfer_engine #(.AW(AW), .DW(DW)) u_dma_xfer_engine (
        .clk(clk), .rst(rst), .start(start), .ctrl_in(ctrl_in),
        .src_end(src_end), .dst_end(dst_end), .chan_req(chan_req),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .err(err),
        .unsup(unsup), .ctrl_out(ctrl_out)
    );

    always #5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc_cnt = 0;
    bit wd_hit  = 0;
    bit rdy_mode = 0;
    bit req_mode = 0;

    logic [31:0] log_addr [LOGN];
    logic [31:0] log_data [LOGN];
    logic        log_wr   [LOGN];
    logic [1:0]  log_size [LOGN];
    int          n_log    = 0;
    int          done_cnt = 0;
    int          idle_cnt = 0;
    bit          err_seen = 0;
    bit          uns_seen = 0;
    logic [31:0] last_wb  = '0;

    function automatic logic [31:0] rd_val(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] eaddr(input logic [31:0] e, input int nm1,
                                          input int k, input logic [1:0] st);
        if (st == 2'd3) return e;
        return e - (32'(nm1 - k) << st);
    endfunction

    function automatic logic [31:0] mk(input logic [1:0] dinc, input logic [1:0] dsz,
                                       input logic [1:0] sinc, input logic [1:0] ssz,
                                       input logic [5:0] prot, input logic [3:0] r,
                                       input logic [9:0] nm1, input logic bn,
                                       input logic [2:0] ty);
        return {dinc, dsz, sinc, ssz, prot, r, nm1, bn, ty};
    endfunction

    assign mem_rdata = rd_val(mem_addr);

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic chk(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Monitor: samples pre-edge values of the handshake and status.
    always @(posedge clk) begin
        cyc_cnt++;
        if (mem_valid && mem_ready && n_log < LOGN) begin
            log_addr[n_log] = mem_addr;
            log_wr[n_log]   = mem_write;
            log_data[n_log] = mem_write ? mem_wdata : mem_rdata;
            log_size[n_log] = mem_size;
            n_log++;
        end
        if (done) begin
            done_cnt++;
            if (err)   err_seen = 1;
            if (unsup) uns_seen = 1;
            last_wb = ctrl_out;
        end
        if (busy && !mem_valid && !done) idle_cnt++;
        if (cyc_cnt > WD_LIMIT && !wd_hit) begin
            wd_hit = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc_cnt, WD_LIMIT);
            summary();
        end
    end

    always @(negedge clk) begin
        mem_ready = rdy_mode ? (($urandom % 10) < 7) : 1'b1;
        if (req_mode) chan_req = ($urandom % 2) == 0;
    end

    task automatic clear_obs();
        n_log = 0; done_cnt = 0; idle_cnt = 0; err_seen = 0; uns_seen = 0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (done_cnt == 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic check_result(input logic [31:0] c, input logic [31:0] s,
                                input logic [31:0] d, input int exp_idle,
                                input string tag);
        int nm1, n, ty;
        logic [1:0] sw, dw;
        bit bad, empty, e_err, e_uns, run;
        int mism, smism;
        logic [31:0] ma, me, ea_s, ea_d;
        nm1   = int'(c[13:4]);
        n     = nm1 + 1;
        ty    = int'(c[2:0]);
        sw    = c[25:24];
        dw    = c[29:28];
        bad   = (sw == 2'd3) || (dw == 2'd3) || (sw != dw);
        empty = (ty == 0);
        e_err = !empty && bad;
        e_uns = !empty && !bad && (ty >= 3);
        run   = !empty && !bad && (ty == 1 || ty == 2);

        chk(done_cnt == 1, {tag, " R9 done pulse count"}, done_cnt, 1);
        chk(err_seen == e_err, {tag, " R2 error flag"}, err_seen, e_err);
        chk(uns_seen == e_uns, {tag, " R8 unsupported flag"}, uns_seen, e_uns);
        chk(n_log == (run ? 2 * n : 0), {tag, " R3 bus beat count"}, n_log, run ? 2 * n : 0);
        if (run && n_log == 2 * n) begin
            mism = 0; smism = 0; ma = '0; me = '0;
            for (int k = 0; k < n; k++) begin
                ea_s = eaddr(s, nm1, k, c[27:26]);
                ea_d = eaddr(d, nm1, k, c[31:30]);
                if (log_size[2*k] !== sw || log_size[2*k+1] !== sw) smism++;
                if (mism == 0) begin
                    if (log_wr[2*k] !== 1'b0 || log_addr[2*k] !== ea_s) begin
                        mism = 1; ma = log_addr[2*k]; me = ea_s;
                    end else if (log_wr[2*k+1] !== 1'b1 || log_addr[2*k+1] !== ea_d) begin
                        mism = 1; ma = log_addr[2*k+1]; me = ea_d;
                    end else if (log_data[2*k+1] !== rd_val(ea_s)) begin
                        mism = 1; ma = log_data[2*k+1]; me = rd_val(ea_s);
                    end
                end
            end
            chk(mism == 0, {tag, " R4 R3 addresses and data"}, ma, me);
            chk(smism == 0, {tag, " R10 size on bus"}, smism, 0);
        end
        chk(last_wb == (c & ~32'h0000_3FF7), {tag, " R9 write-back word"},
            last_wb, c & ~32'h0000_3FF7);
        chk(!busy, {tag, " R9 idle after done"}, busy, 0);
        if (exp_idle >= 0)
            chk(idle_cnt == exp_idle, {tag, " arbitration idle cycles"}, idle_cnt, exp_idle);
    endtask

    task automatic run_case(input logic [31:0] c, input logic [31:0] s,
                            input logic [31:0] d, input int exp_idle, input string tag);
        @(negedge clk);
        ctrl_in = c; src_end = s; dst_end = d; start = 1'b1;
        clear_obs();
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check_result(c, s, d, exp_idle, tag);
    endtask

    initial begin
        int unused_seed;
        logic [31:0] c;
        unused_seed = $urandom(32'd4242);
        rst = 1'b1; start = 1'b0; chan_req = 1'b0;
        ctrl_in = '0; src_end = '0; dst_end = '0;
        repeat (4) @(negedge clk);
        chk(!busy && !mem_valid && !done && !err && !unsup, "R1 outputs quiet in reset",
            {busy, mem_valid, done, err, unsup}, 0);
        chk(ctrl_out == 32'd0, "R1 write-back word after reset", ctrl_out, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_valid, "R1 idle after reset release", {busy, mem_valid}, 0);

        // Directed cases, bus always ready, request held high.
        chan_req = 1'b1;
        run_case(mk(2, 2, 2, 2, 6'b101101, 0, 3, 1, 1), 32'h2000_0100, 32'h3000_0200, 4,
                 "R5 basic one per group");
        run_case(mk(1, 1, 1, 1, 6'b000000, 1, 5, 0, 2), 32'h2000_1000, 32'h3000_1000, 2,
                 "R6 auto pairs");
        run_case(mk(0, 0, 0, 0, 6'b010010, 2, 4, 1, 2), 32'h0000_0010, 32'h0000_0404, 1,
                 "R6 auto groups of four");
        run_case(mk(3, 2, 3, 2, 6'b000000, 0, 2, 0, 2), 32'h4000_0000, 32'h4000_0040, 2,
                 "R4 hold addressing");
        run_case(mk(2, 0, 0, 0, 6'b001001, 10, 1023, 0, 2), 32'h1000_0000, 32'h5000_0000, 0,
                 "R3 maximum count");
        run_case(mk(2, 2, 1, 2, 6'b000000, 15, 1023, 0, 2), 32'h1000_8000, 32'h5000_8000, 0,
                 "R5 exponent above limit");
        run_case(mk(0, 1, 2, 1, 6'b000000, 0, 0, 0, 2), 32'h0000_0002, 32'h0000_0000, 0,
                 "R3 single transfer wraps");
        run_case(mk(2, 2, 2, 2, 6'b111111, 3, 9, 1, 0), 32'h1, 32'h2, -1, "R7 type zero");
        for (int t = 3; t < 8; t++)
            run_case(mk(1, 1, 1, 1, 6'b100100, 1, 7, 1, 3'(t)), 32'h100, 32'h200, -1,
                     "R8 unsupported type");
        run_case(mk(2, 2, 2, 3, 6'b0, 0, 3, 0, 1), 32'h100, 32'h200, -1, "R2 reserved size");
        run_case(mk(2, 1, 2, 2, 6'b0, 0, 3, 0, 2), 32'h100, 32'h200, -1, "R2 size mismatch");
        run_case(mk(2, 3, 2, 2, 6'b0, 0, 3, 0, 6), 32'h100, 32'h200, -1, "R8 error wins");

        // Basic cycle stalled on the request line; start pulses ignored.
        chan_req = 1'b0;
        c = mk(2, 2, 2, 2, 6'b0, 1, 7, 0, 1);
        @(negedge clk);
        ctrl_in = c; src_end = 32'h6000_0000; dst_end = 32'h7000_0000; start = 1'b1;
        clear_obs();
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        chk(n_log == 0 && busy, "R5 basic waits for request", n_log, 0);
        ctrl_in = mk(2, 2, 2, 2, 6'b0, 0, 0, 0, 0); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        chk(done_cnt == 0 && n_log == 0 && busy, "R11 start ignored while busy", done_cnt, 0);
        chan_req = 1'b1;
        @(negedge clk);
        chan_req = 1'b0;
        repeat (20) @(negedge clk);
        chk(n_log == 4, "R5 one group per request", n_log, 4);
        chan_req = 1'b1;
        wait_done();
        check_result(c, 32'h6000_0000, 32'h7000_0000, -1, "R5 stalled basic");

        // Random cycles with a slow bus and a random request line.
        rdy_mode = 1'b1;
        req_mode = 1'b1;
        for (int i = 0; i < 60; i++) begin
            logic [1:0] sz, szd;
            logic [2:0] ty;
            logic [3:0] r;
            logic [9:0] nm1;
            int g, groups, ei;
            sz  = 2'($urandom % 3);
            szd = (($urandom % 10) == 0) ? 2'($urandom % 4) : sz;
            ty  = (($urandom % 8) == 0) ? 3'($urandom % 8) : 3'(1 + ($urandom % 2));
            r   = 4'($urandom % 16);
            nm1 = 10'($urandom % 48);
            c   = mk(2'($urandom % 4), szd, 2'($urandom % 4), sz, 6'($urandom % 64),
                     r, nm1, 1'($urandom % 2), ty);
            g      = 1 << ((r > 10) ? 10 : int'(r));
            groups = (int'(nm1) + 1 + g - 1) / g;
            ei     = (ty == 3'd2 && szd == sz) ? groups - 1 : -1;
            run_case(c, $urandom, $urandom, ei, "R6 random");
        end

        summary();
    end
endmodule